// File: doc/BRIEF.md
# Counter-Based Power-On Reset Generator

This block produces a single active-high reset pulse shortly after the device is configured. It needs no external reset circuit. It relies on its flip-flops taking a known value at configuration: either all zeros or all ones.

A small counter runs on one of the system clocks. It advances from its power-up value and opens a reset window between a lower preset count and an upper preset count. When it reaches the upper preset it stops for good, so the pulse happens once per power-up. The window decode is registered, so the generated pulse changes only on a clock edge.

The pulse is ORed with an external active-high reset request. Downstream logic, such as pseudo-random generators that must load nonzero seeds, sees a reset from either source. The external request never restarts or delays the counter.

Top module: `por_gen_top`

## Requirements
- R1: At configuration the counter holds its power-up value. `INIT_ONES=0` selects all zeros and `INIT_ONES=1` selects all ones. No reset signal acts on the counter, and `rst_o` is low before the first rising clock edge while `ext_rst_i` is low.
- R2: On every rising edge the counter adds one, wrapping from all ones to zero, until it equals `HI`. From then on it holds `HI` permanently.
- R3: The pulse is registered. On a rising edge the pulse register loads 1 exactly when the counter held a value v with `LO <= v < HI` before that edge. With `LO=2`, `HI=4` and an all-zeros start, `rst_o` (with `ext_rst_i` low) is high after edges 3 and 4 only, which is `HI-LO` = 2 cycles.
- R4: With an all-ones start, the wrap from 15 to 0 produces no pulse. The pulse then follows one edge later than in R3: `rst_o` is high after edges 4 and 5 only.
- R5: After the pulse ends, `rst_o` stays low for as long as `ext_rst_i` stays low.
- R6: Whenever `ext_rst_i` is high, `rst_o` is high in the same cycle, whatever the counter state.
- R7: Asserting `ext_rst_i`, including during the window, does not restart or shift the counter. At every edge the generated pulse matches R3, and `rst_o` equals `ext_rst_i` OR that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that drives the counter |
| ext_rst_i | input | 1 | External reset request, active high |
| rst_o | output | 1 | Combined reset, active high: the generated pulse OR `ext_rst_i` |

## Verification
The generated pulse and the external request can both be high in the same cycle. The bench provokes this by driving a pattern on `ext_rst_i` that starts before the window, stays high across it and toggles after it. Every cycle, the output is judged against the OR of the driven request and a pulse computed from the edge count alone. A second instance that never sees the external request confirms that the pulse timing does not shift. An instance that starts at all ones shows that the wrap produces no extra pulse.

// File: rtl/por_gen_pkg.sv
`timescale 1ns/1ps
package por_gen_pkg;
  // true when a count lies inside the half-open reset window
  function automatic logic in_window(int unsigned v, int unsigned lo, int unsigned hi);
    return (v >= lo) && (v < hi);
  endfunction
endpackage

// File: rtl/por_gen_count.sv
`timescale 1ns/1ps
module por_gen_count #(
  parameter int unsigned W         = 4,
  parameter int unsigned HI        = 4,
  parameter bit          INIT_ONES = 1'b0
) (
  input  logic         clk_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] INIT = INIT_ONES ? {W{1'b1}} : {W{1'b0}};
  localparam logic [W-1:0] STOP = W'(HI);

  // power-up value only; no reset by design
  logic [W-1:0] cnt_q = INIT;

  always_ff @(posedge clk_i) begin
    if (cnt_q != STOP) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/por_gen_window.sv
`timescale 1ns/1ps
module por_gen_window #(
  parameter int unsigned W  = 4,
  parameter int unsigned LO = 2,
  parameter int unsigned HI = 4
) (
  input  logic         clk_i,
  input  logic [W-1:0] cnt_i,
  output logic         por_o
);
  logic por_q = 1'b0;

  always_ff @(posedge clk_i) begin
    por_q <= por_gen_pkg::in_window(int'(cnt_i), LO, HI);
  end

  assign por_o = por_q;
endmodule

// File: rtl/por_gen_merge.sv
`timescale 1ns/1ps
module por_gen_merge (
  input  logic por_i,
  input  logic ext_rst_i,
  output logic rst_o
);
  assign rst_o = por_i | ext_rst_i;
endmodule

// File: rtl/por_gen_top.sv
`timescale 1ns/1ps
module por_gen_top #(
  parameter int unsigned W         = 4,
  parameter int unsigned LO        = 2,
  parameter int unsigned HI        = 4,
  parameter bit          INIT_ONES = 1'b0
) (
  input  logic clk_i,
  input  logic ext_rst_i,
  output logic rst_o
);
  localparam int unsigned ALL_ONES = (1 << W) - 1;

  // all-ones start must sit outside the window and never be the stop value
  if (!(LO < HI && HI < ALL_ONES)) begin : g_cfg_bad
    $error("por_gen_top: need LO < HI < 2**W-1");
  end

  logic [W-1:0] cnt_w;
  logic         por_w;

  por_gen_count #(.W(W), .HI(HI), .INIT_ONES(INIT_ONES)) u_count (
    .clk_i (clk_i),
    .cnt_o (cnt_w)
  );

  por_gen_window #(.W(W), .LO(LO), .HI(HI)) u_window (
    .clk_i (clk_i),
    .cnt_i (cnt_w),
    .por_o (por_w)
  );

  por_gen_merge u_merge (
    .por_i     (por_w),
    .ext_rst_i (ext_rst_i),
    .rst_o     (rst_o)
  );
endmodule

// File: rtl/por_gen_chk.sv
`timescale 1ns/1ps
module por_gen_chk #(
  parameter int unsigned W  = 4,
  parameter int unsigned LO = 2,
  parameter int unsigned HI = 4
) (
  input logic         clk_i,
  input logic         ext_rst_i,
  input logic         rst_o,
  input logic [W-1:0] cnt,
  input logic         por
);
  localparam logic [W-1:0] LOV = W'(LO);
  localparam logic [W-1:0] HIV = W'(HI);

  logic started_q = 1'b0;
  always_ff @(posedge clk_i) started_q <= 1'b1;

  a_r6_ext_forces: assert property (@(posedge clk_i) disable iff (!started_q)
    ext_rst_i |-> rst_o);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!started_q)
    (cnt == HIV) |=> (cnt == HIV));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!started_q)
    (cnt != HIV) |=> (cnt == $past(cnt) + W'(1)));

  a_r3_window: assert property (@(posedge clk_i) disable iff (!started_q)
    (cnt >= LOV && cnt < HIV) |=> por);

  a_r4_no_wrap_pulse: assert property (@(posedge clk_i) disable iff (!started_q)
    (cnt == {W{1'b1}}) |=> !por);

  a_r5_quiet: assert property (@(posedge clk_i) disable iff (!started_q)
    (cnt == HIV && !por) |=> !por);
endmodule

bind por_gen_top por_gen_chk #(.W(W), .LO(LO), .HI(HI)) u_chk (
  .clk_i     (clk_i),
  .ext_rst_i (ext_rst_i),
  .rst_o     (rst_o),
  .cnt       (cnt_w),
  .por       (por_w)
);

// File: tb/por_gen_top_bench.sv
`timescale 1ns/1ps
module por_gen_top_bench;
  localparam int W  = 4;
  localparam int LO = 2;
  localparam int HI = 4;
  localparam int NCYC = 40;

  logic clk = 1'b0;
  logic ext_a = 1'b0, ext_b = 1'b0, ext_c = 1'b0;
  logic rst_a, rst_b, rst_c;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  por_gen_top #(.W(W), .LO(LO), .HI(HI), .INIT_ONES(1'b0)) u_por_gen_top (
    .clk_i(clk), .ext_rst_i(ext_a), .rst_o(rst_a));
  por_gen_top #(.W(W), .LO(LO), .HI(HI), .INIT_ONES(1'b1)) u_por_gen_top_ones (
    .clk_i(clk), .ext_rst_i(ext_b), .rst_o(rst_b));
  por_gen_top #(.W(W), .LO(LO), .HI(HI), .INIT_ONES(1'b0)) u_por_gen_top_ext (
    .clk_i(clk), .ext_rst_i(ext_c), .rst_o(rst_c));

  // counter value after k edges
  function automatic int cnt_after(int k, bit ones);
    int v;
    if (ones) begin
      if (k == 0) return (1 << W) - 1;
      v = k - 1;
    end else v = k;
    return (v > HI) ? HI : v;
  endfunction

  function automatic bit por_after(int k, bit ones);
    int v;
    if (k == 0) return 1'b0;
    v = cnt_after(k - 1, ones);
    return (v >= LO) && (v < HI);
  endfunction

  task automatic check(string req, logic act, logic exp, int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  initial begin
    int hi_a, hi_b;
    logic ea, ec;
    hi_a = 0;
    hi_b = 0;
    #1;
    // R1: before any edge
    check("R1", rst_a, 1'b0, 0);
    check("R1", rst_b, 1'b0, 0);
    check("R1", rst_c, 1'b0, 0);
    for (int i = 1; i <= NCYC; i++) begin
      @(negedge clk);
      ea = por_after(i, 1'b0);
      check(i <= HI ? "R3" : "R5", rst_a, ea, i);
      check(i <= HI + 1 ? "R4" : "R5", rst_b, por_after(i, 1'b1), i);
      ec = ext_c | ea;
      check(ext_c ? "R6" : "R7", rst_c, ec, i);
      if (rst_a === 1'b1) hi_a++;
      if (rst_b === 1'b1) hi_b++;
      // external pattern spanning the window, then sparse toggles
      ext_c = (i >= 2 && i <= 5) || (i % 7 == 0) || (i >= 30 && i <= 32);
      #0.5;
      check("R6", rst_c, ext_c | ea, i);
    end
    // late external request on the all-zeros instance after the pulse
    ext_a = 1'b1;
    #0.5;
    check("R6", rst_a, 1'b1, NCYC);
    @(negedge clk);
    ext_a = 1'b0;
    #0.5;
    check("R5", rst_a, 1'b0, NCYC + 1);
    check("R3", hi_a == HI - LO, 1'b1, NCYC);
    check("R4", hi_b == HI - LO, 1'b1, NCYC);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule